// File: doc/BRIEF.md
# Two-Stage Key Unlock Controller

This block holds two write guards for a set of protected configuration registers. A main guard covers the control register, and an option guard covers the option-related fields inside it. Each guard reopens only when software writes two fixed 32-bit key words, in order, to that guard's own key address on a simple single-cycle write bus. After reset both guards are closed. Software can close either guard again at any moment by writing a one to its lock bit in the control register word. Only the key hardware can open a guard.

Any key write that does not match the word the guard expects next freezes that guard. A write that arrives after the guard is already open also freezes it. A frozen guard stays closed and ignores all further keys and relock requests until reset. The option guard also depends on the main guard: an option key write made while the main guard is closed counts as a wrong key. The block gives the state of both guards. It also gives two write-enable qualifiers, which the surrounding register file uses to gate writes to ordinary control fields and to option fields.

Top module: `keyUnlockCtrl`

## Requirements
- R1: After reset, `mainLocked` and `optLocked` are 1, `mainFrozen` and `optFrozen` are 0, and both write-allow outputs are 0.
- R2: The main guard opens (`mainLocked` falls to 0) only after two consecutive enabled writes to key address 2: first 0x45670123, then 0xCDEF89AB.
- R3: While the main guard is open, the option guard opens only after two consecutive enabled writes to option key address 3: first 0x08192A3B, then 0x4C5D6E7F.
- R4: A key write whose value is not the next expected word freezes that guard. The frozen flag goes to 1 and the guard stays closed. The flag stays set until reset, and later correct key pairs have no effect.
- R5: An option key write made while the main guard is closed freezes the option guard, even if the value would be correct.
- R6: A key write to a guard that is already open closes and freezes that guard.
- R7: An enabled write to control address 5 with bit 31 set closes the main guard. With bit 30 set, it closes the option guard. A guard that is not frozen then waits for its first key again and can be reopened.
- R8: A relock request has no effect on a frozen guard. The guard stays frozen and cannot be opened.
- R9: A relock between the first and second key aborts the sequence. A following second key word then counts as wrong and freezes the guard.
- R10: `ctrlWrAllow` is 1 exactly when the main guard is open. `optWrAllow` is 1 exactly when both guards are open.
- R11: Key writes to one guard's address never change the other guard. Writes to any other address change neither guard.
- R12: Bus cycles with `busWrEn` low change nothing, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busAddr | input | ADDR_W (4) | Word address of the write |
| busWrData | input | DATA_W (32) | Write data |
| mainLocked | output | 1 | Main guard closed |
| optLocked | output | 1 | Option guard closed |
| mainFrozen | output | 1 | Main guard frozen until reset |
| optFrozen | output | 1 | Option guard frozen until reset |
| ctrlWrAllow | output | 1 | Qualifier for writes to ordinary control fields |
| optWrAllow | output | 1 | Qualifier for writes to option fields |

## Verification
The assertions check several properties on every cycle. A guard may open only in the cycle after the correct second key, and the option guard only while the main guard is open. Frozen guards stay frozen and closed. A relock write always leaves its guard closed. Idle bus cycles keep both guards unchanged.

Only the bench scenarios can show the rest. These are which exact write orders open a guard, the freezing after wrong, early or late keys, and a relock that restarts a sequence or aborts it halfway. A relock that cannot rescue a frozen guard also needs a scenario. The bench sweeps every ordered pair drawn from both key words and a wrong word, for each guard, and follows each pair with one more key write.

// File: rtl/keyUnlockPkg.sv
package keyUnlockPkg;

  localparam int NUM_LOCKS = 2;
  localparam int LOCK_MAIN = 0;
  localparam int LOCK_OPT  = 1;

  typedef enum logic [1:0] {
    SEQ_WAIT1  = 2'd0,
    SEQ_WAIT2  = 2'd1,
    SEQ_OPEN   = 2'd2,
    SEQ_FROZEN = 2'd3
  } seqState_t;

  // Per-guard strobes from the decoder to the sequencers.
  typedef struct packed {
    logic keyWr;     // key write aimed at this guard
    logic firstOk;   // value equals first key and gate allows
    logic secondOk;  // value equals second key and gate allows
    logic relock;    // software request to close the guard
  } lockStrobe_t;

endpackage

// File: rtl/keyUnlockDecode.sv
module keyUnlockDecode
  import keyUnlockPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] OPTKEY_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h5,
  parameter int MAIN_LOCK_BIT = 31,
  parameter int OPT_LOCK_BIT = 30,
  parameter logic [DATA_W-1:0] MAIN_KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] MAIN_KEY2 = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY1 = 32'h0819_2A3B,
  parameter logic [DATA_W-1:0] OPT_KEY2 = 32'h4C5D_6E7F
) (
  input  logic                         busWrEn,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic [DATA_W-1:0]            busWrData,
  input  logic                         mainLocked,
  output lockStrobe_t [NUM_LOCKS-1:0]  strobes
);

  logic ctrlHit;
  assign ctrlHit = busWrEn && (busAddr == CTRL_ADDR);

  for (genvar gv = 0; gv < NUM_LOCKS; gv++) begin : g_lock
    localparam bit IS_OPT = (gv == LOCK_OPT);
    localparam logic [ADDR_W-1:0] MY_ADDR = IS_OPT ? OPTKEY_ADDR : KEY_ADDR;
    localparam logic [DATA_W-1:0] MY_KEY1 = IS_OPT ? OPT_KEY1 : MAIN_KEY1;
    localparam logic [DATA_W-1:0] MY_KEY2 = IS_OPT ? OPT_KEY2 : MAIN_KEY2;
    localparam int MY_BIT = IS_OPT ? OPT_LOCK_BIT : MAIN_LOCK_BIT;

    logic gateOk;
    // The option sequence is accepted only behind an open main guard.
    assign gateOk = IS_OPT ? !mainLocked : 1'b1;

    always_comb begin
      strobes[gv].keyWr    = busWrEn && (busAddr == MY_ADDR);
      strobes[gv].firstOk  = gateOk && (busWrData == MY_KEY1);
      strobes[gv].secondOk = gateOk && (busWrData == MY_KEY2);
      strobes[gv].relock   = ctrlHit && busWrData[MY_BIT];
    end
  end

endmodule

// File: rtl/keyUnlockSeq.sv
module keyUnlockSeq
  import keyUnlockPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  lockStrobe_t strobe,
  output logic        locked,
  output logic        frozen
);

  seqState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    if (strobe.keyWr) begin
      unique case (state)
        SEQ_WAIT1: stateNxt = strobe.firstOk  ? SEQ_WAIT2 : SEQ_FROZEN;
        SEQ_WAIT2: stateNxt = strobe.secondOk ? SEQ_OPEN  : SEQ_FROZEN;
        default:   stateNxt = SEQ_FROZEN;
      endcase
    end else if (strobe.relock && state != SEQ_FROZEN) begin
      stateNxt = SEQ_WAIT1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_WAIT1;
    else       state <= stateNxt;
  end

  assign locked = (state != SEQ_OPEN);
  assign frozen = (state == SEQ_FROZEN);

endmodule

// File: rtl/keyUnlockBank.sv
module keyUnlockBank
  import keyUnlockPkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  lockStrobe_t [NUM_LOCKS-1:0] strobes,
  output logic [NUM_LOCKS-1:0]        lockedVec,
  output logic [NUM_LOCKS-1:0]        frozenVec,
  output logic                        ctrlWrAllow,
  output logic                        optWrAllow
);

  for (genvar gv = 0; gv < NUM_LOCKS; gv++) begin : g_seq
    keyUnlockSeq u_seq (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[gv]),
      .locked (lockedVec[gv]),
      .frozen (frozenVec[gv])
    );
  end

  assign ctrlWrAllow = !lockedVec[LOCK_MAIN];
  assign optWrAllow  = !lockedVec[LOCK_MAIN] && !lockedVec[LOCK_OPT];

endmodule

// File: rtl/keyUnlockCtrl.sv
module keyUnlockCtrl
  import keyUnlockPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] OPTKEY_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h5,
  parameter int MAIN_LOCK_BIT = 31,
  parameter int OPT_LOCK_BIT = 30,
  parameter logic [DATA_W-1:0] MAIN_KEY1 = 32'h4567_0123,
  parameter logic [DATA_W-1:0] MAIN_KEY2 = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY1 = 32'h0819_2A3B,
  parameter logic [DATA_W-1:0] OPT_KEY2 = 32'h4C5D_6E7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic              mainLocked,
  output logic              optLocked,
  output logic              mainFrozen,
  output logic              optFrozen,
  output logic              ctrlWrAllow,
  output logic              optWrAllow
);

  lockStrobe_t [NUM_LOCKS-1:0] strobes;
  logic [NUM_LOCKS-1:0] lockedVec;
  logic [NUM_LOCKS-1:0] frozenVec;

  keyUnlockDecode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .KEY_ADDR(KEY_ADDR), .OPTKEY_ADDR(OPTKEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .MAIN_LOCK_BIT(MAIN_LOCK_BIT), .OPT_LOCK_BIT(OPT_LOCK_BIT),
    .MAIN_KEY1(MAIN_KEY1), .MAIN_KEY2(MAIN_KEY2),
    .OPT_KEY1(OPT_KEY1), .OPT_KEY2(OPT_KEY2)
  ) u_decode (
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .mainLocked (lockedVec[LOCK_MAIN]),
    .strobes    (strobes)
  );

  keyUnlockBank u_bank (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lockedVec   (lockedVec),
    .frozenVec   (frozenVec),
    .ctrlWrAllow (ctrlWrAllow),
    .optWrAllow  (optWrAllow)
  );

  assign mainLocked = lockedVec[LOCK_MAIN];
  assign optLocked  = lockedVec[LOCK_OPT];
  assign mainFrozen = frozenVec[LOCK_MAIN];
  assign optFrozen  = frozenVec[LOCK_OPT];

endmodule

// File: rtl/keyUnlockChecker.sv
module keyUnlockChecker #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h2,
  parameter logic [ADDR_W-1:0] OPTKEY_ADDR = 4'h3,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h5,
  parameter int MAIN_LOCK_BIT = 31,
  parameter int OPT_LOCK_BIT = 30,
  parameter logic [DATA_W-1:0] MAIN_KEY2 = 32'hCDEF_89AB,
  parameter logic [DATA_W-1:0] OPT_KEY2 = 32'h4C5D_6E7F
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              mainLocked,
  input logic              optLocked,
  input logic              mainFrozen,
  input logic              optFrozen,
  input logic              ctrlWrAllow,
  input logic              optWrAllow
);

  p_main_open_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainLocked) |-> $past(busWrEn && busAddr == KEY_ADDR && busWrData == MAIN_KEY2));

  p_opt_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(optLocked) |-> $past(busWrEn && busAddr == OPTKEY_ADDR
                               && busWrData == OPT_KEY2 && !mainLocked));

  p_main_frozen_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    mainFrozen |=> mainFrozen && mainLocked);

  p_opt_frozen_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    optFrozen |=> optFrozen && optLocked);

  p_main_relock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CTRL_ADDR && busWrData[MAIN_LOCK_BIT]) |=> mainLocked);

  p_opt_relock_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == CTRL_ADDR && busWrData[OPT_LOCK_BIT]) |=> optLocked);

  p_allow_chain_r10: assert property (@(posedge clk) disable iff (!rstN)
    optWrAllow |-> (ctrlWrAllow && !optLocked));

  p_idle_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> ($stable(mainLocked) && $stable(optLocked)
                  && $stable(mainFrozen) && $stable(optFrozen)));

endmodule

bind keyUnlockCtrl keyUnlockChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .KEY_ADDR(KEY_ADDR), .OPTKEY_ADDR(OPTKEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
  .MAIN_LOCK_BIT(MAIN_LOCK_BIT), .OPT_LOCK_BIT(OPT_LOCK_BIT),
  .MAIN_KEY2(MAIN_KEY2), .OPT_KEY2(OPT_KEY2)
) u_checker (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .mainLocked(mainLocked), .optLocked(optLocked),
  .mainFrozen(mainFrozen), .optFrozen(optFrozen),
  .ctrlWrAllow(ctrlWrAllow), .optWrAllow(optWrAllow)
);

// File: tb/keyUnlockCtrl_bench.sv
module keyUnlockCtrl_bench;

  localparam logic [3:0]  A_KEY  = 4'h2;
  localparam logic [3:0]  A_OKEY = 4'h3;
  localparam logic [3:0]  A_CTRL = 4'h5;
  localparam logic [3:0]  A_MISC = 4'h7;
  localparam logic [31:0] BAD    = 32'hDEAD_BEEF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic mainLocked, optLocked, mainFrozen, optFrozen, ctrlWrAllow, optWrAllow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference state per guard: 0 wait first, 1 wait second, 2 open, 3 frozen.
  int mSt [2];
  logic [31:0] keyA [2];
  logic [31:0] keyB [2];

  always #5ns clk = ~clk;

  keyUnlockCtrl u_keyUnlockCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .mainLocked(mainLocked), .optLocked(optLocked),
    .mainFrozen(mainFrozen), .optFrozen(optFrozen),
    .ctrlWrAllow(ctrlWrAllow), .optWrAllow(optWrAllow)
  );

  function automatic int stepKey(int st, logic [31:0] d, int idx, bit gate);
    if (st == 0) return (gate && d == keyA[idx]) ? 1 : 3;
    if (st == 1) return (gate && d == keyB[idx]) ? 2 : 3;
    return 3;
  endfunction

  task automatic modelWrite(logic [3:0] a, logic [31:0] d);
    if (a == A_KEY)  mSt[0] = stepKey(mSt[0], d, 0, 1'b1);
    else if (a == A_OKEY) mSt[1] = stepKey(mSt[1], d, 1, mSt[0] == 2);
    else if (a == A_CTRL) begin
      if (d[31] && mSt[0] != 3) mSt[0] = 0;
      if (d[30] && mSt[1] != 3) mSt[1] = 0;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mSt[0] = 0;
    mSt[1] = 0;
    @(negedge clk);
  endtask

  task automatic wr(bit en, logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busWrEn = en;
    busAddr = a;
    busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
    if (en) modelWrite(a, d);
  endtask

  task automatic checkAll(string req);
    logic [5:0] act, exp;
    act = {mainLocked, optLocked, mainFrozen, optFrozen, ctrlWrAllow, optWrAllow};
    exp = {mSt[0] != 2, mSt[1] != 2, mSt[0] == 3, mSt[1] == 3,
           mSt[0] == 2, (mSt[0] == 2) && (mSt[1] == 2)};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: outputs actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(int idx, int sel);
    if (sel == 0) return keyA[idx];
    if (sel == 1) return keyB[idx];
    return BAD;
  endfunction

  initial begin
    keyA[0] = 32'h4567_0123; keyB[0] = 32'hCDEF_89AB;
    keyA[1] = 32'h0819_2A3B; keyB[1] = 32'h4C5D_6E7F;
    mSt[0] = 0; mSt[1] = 0;

    doReset();
    checkAll("R1");

    // Main guard: every ordered pair, then one more key write.
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        doReset();
        wr(1'b1, A_KEY, pick(0, a));
        wr(1'b1, A_KEY, pick(0, b));
        checkAll((a == 0 && b == 1) ? "R2" : "R4");
        wr(1'b1, A_KEY, keyA[0]);
        checkAll((a == 0 && b == 1) ? "R6" : "R4");
      end
    end

    // Option guard behind an open main guard.
    for (int a = 0; a < 3; a++) begin
      for (int b = 0; b < 3; b++) begin
        doReset();
        wr(1'b1, A_KEY, keyA[0]);
        wr(1'b1, A_KEY, keyB[0]);
        wr(1'b1, A_OKEY, pick(1, a));
        wr(1'b1, A_OKEY, pick(1, b));
        checkAll((a == 0 && b == 1) ? "R3" : "R4");
        wr(1'b1, A_OKEY, keyA[1]);
        checkAll((a == 0 && b == 1) ? "R6" : "R4");
      end
    end

    // Option keys while main guard is closed.
    doReset();
    wr(1'b1, A_OKEY, keyA[1]);
    wr(1'b1, A_OKEY, keyB[1]);
    checkAll("R5");
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b1, A_KEY, keyB[0]);
    wr(1'b1, A_OKEY, keyA[1]);
    wr(1'b1, A_OKEY, keyB[1]);
    checkAll("R4");

    // Relock and reopen both guards.
    doReset();
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b1, A_KEY, keyB[0]);
    wr(1'b1, A_OKEY, keyA[1]);
    wr(1'b1, A_OKEY, keyB[1]);
    checkAll("R10");
    wr(1'b1, A_CTRL, 32'h4000_0000);
    checkAll("R7");
    wr(1'b1, A_OKEY, keyA[1]);
    wr(1'b1, A_OKEY, keyB[1]);
    checkAll("R7");
    wr(1'b1, A_CTRL, 32'h8000_0000);
    checkAll("R7");
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b1, A_KEY, keyB[0]);
    checkAll("R7");

    // Relock does not rescue a frozen guard.
    doReset();
    wr(1'b1, A_KEY, BAD);
    wr(1'b1, A_CTRL, 32'hC000_0000);
    checkAll("R8");
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b1, A_KEY, keyB[0]);
    checkAll("R8");

    // Relock between the two keys aborts the sequence.
    doReset();
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b1, A_CTRL, 32'h8000_0000);
    wr(1'b1, A_KEY, keyB[0]);
    checkAll("R9");

    // Isolation between guards and from other addresses.
    doReset();
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b1, A_KEY, keyB[0]);
    wr(1'b1, A_OKEY, BAD);
    checkAll("R11");
    wr(1'b1, A_MISC, keyA[0]);
    wr(1'b1, A_MISC, 32'hFFFF_FFFF);
    checkAll("R11");

    // Disabled bus cycles do nothing.
    doReset();
    wr(1'b0, A_KEY, BAD);
    wr(1'b0, A_OKEY, BAD);
    checkAll("R12");
    wr(1'b1, A_KEY, keyA[0]);
    wr(1'b0, A_KEY, BAD);
    wr(1'b1, A_KEY, keyB[0]);
    checkAll("R12");
    wr(1'b0, A_CTRL, 32'hC000_0000);
    checkAll("R12");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule